// File: doc/BRIEF.md
# Divider and Programmable Timer

This peripheral keeps a free-running 16-bit cycle counter that advances by a fixed step on every machine-cycle tick. The upper byte of that counter is visible as a read-only-style divider value: any write to it clears the whole counter. Next to it sits an 8-bit timer counter with a modulo (reload) register and a 3-bit control register. The timer counter advances on a falling edge of one selected counter bit, gated by an enable bit. A falling edge can come from the counter advancing, from the counter being cleared, or from a control write.

When the timer counter wraps past its all-ones value, it reads zero until the next tick. On that tick the modulo value is loaded into the timer counter and a single-cycle interrupt request is emitted for an external flag register to latch. Writes that land during the wrap delay or during the reload window follow dedicated conflict rules. Software-side access uses a 2-bit register select with a write strobe and a combinational read port.

Top module: `divtimer_top`

## Requirements
- R1: After reset the cycle counter, timer counter, modulo and control registers all read zero and the interrupt request is low.
- R2: Each clock with the tick input high adds 4 to the 16-bit cycle counter. Read select 0 returns the counter's upper 8 bits. With no tick and no write, the counter holds.
- R3: A write with select 0 clears the whole 16-bit counter to zero, whatever the data.
- R4: The control register is select 3. Its bit 2 enables the timer. Its bits 1:0 pick the counter bit that drives the timer: 0 picks bit 9, 1 picks bit 3, 2 picks bit 5 and 3 picks bit 7. The timer counter (select 1) increments when (enable AND picked bit) falls from 1 to 0 as the counter changes.
- R5: A counter clear by a select-0 write that drops (enable AND picked bit) from 1 to 0 increments the timer counter once.
- R6: A control write that drops (enable AND picked bit) from 1 to 0 increments the timer counter once. A write that raises it or leaves it unchanged does not.
- R7: When the timer counter wraps from 0xFF, it reads 0x00 until the next tick. On that tick the modulo register (select 2) is copied into it, and irq_o is high for exactly the clock after that edge.
- R8: A timer-counter write between the wrap and the reload tick cancels both the interrupt and the reload. The written value remains.
- R9: From the reload tick up to the next tick, timer-counter writes are ignored. A modulo write in that window also goes into the timer counter.
- R10: When a write and a tick fall in the same clock, the tick's update is applied first and the write then takes effect on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One machine-cycle tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 divider, 1 timer counter, 2 modulo, 3 control |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | 8 | Selected register value (control zero-extended) |
| irq_o | output | 1 | Single-cycle timer interrupt request |

## Verification
On every cycle, the assertions check the counter step and hold, the clear on a divider write, and the wrap into a pending state. They also check the reload of the modulo value, the cancel on a timer write during the delay, and that writes are ignored in the reload window. They also check the single increment caused by a write-side falling edge. Three behaviours only show up in the bench's scenarios, which a cycle model follows on every clock: the timing of an increment for each rate selection, how a tick combines with a write in the same clock, and the interrupt seen at the port relative to the reload.

// File: rtl/divtimer_pkg.sv
`timescale 1ns/1ps
package divtimer_pkg;
  localparam int CTL_W = 3;
  localparam logic [1:0] SEL_DIV = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_MOD = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // rate code to counter bit position
  function automatic int rate_bit(input logic [1:0] rate);
    case (rate)
      2'd0:    return 9;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/divtimer_bitsel.sv
`timescale 1ns/1ps
module divtimer_bitsel #(
  parameter int CNT_W = 16
) (
  input  logic [divtimer_pkg::CTL_W-1:0] ctl_i,
  input  logic [CNT_W-1:0]               cnt_i,
  output logic                           lvl_o
);
  logic picked;
  always_comb begin
    picked = cnt_i[divtimer_pkg::rate_bit(ctl_i[1:0])];
    lvl_o  = ctl_i[2] & picked;
  end
endmodule

// File: rtl/divtimer_counter.sv
`timescale 1ns/1ps
module divtimer_counter #(
  parameter int CNT_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_tick_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_tick_o = tick_i ? (cnt_q + STEP_V) : cnt_q;
    cnt_next_o = clr_i ? '0 : cnt_tick_o;
    cnt_en     = tick_i | clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_next_o;
    end
  end

  assign cnt_o = cnt_q;

  // R2: one tick advances by the step
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_i && !clr_i |=> cnt_q == $past(cnt_q) + STEP_V);
  // R2: idle clocks hold the counter
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !tick_i && !clr_i |=> $stable(cnt_q));
  // R3: divider write clears everything
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/divtimer_core.sv
`timescale 1ns/1ps
module divtimer_core #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             tick_i,
  input  logic             inc_tick_i,
  input  logic             inc_wr_i,
  input  logic             wr_cnt_i,
  input  logic             wr_mod_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output logic [TMR_W-1:0] tc_o,
  output logic [TMR_W-1:0] tmod_o,
  output logic             irq_o
);
  localparam logic [TMR_W-1:0] ALL1 = {TMR_W{1'b1}};
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);

  logic [TMR_W-1:0] tc_q, tc_d, tmod_q, tmod_d;
  logic             pend_q, pend_d, load_q, load_d, irq_q, irq_d;
  logic             tc_en, mod_en;

  always_comb begin
    tc_d   = tc_q;
    tmod_d = tmod_q;
    pend_d = pend_q;
    load_d = load_q;
    irq_d  = 1'b0;
    // tick phase: deliver a pending wrap, then advance
    if (tick_i) begin
      load_d = 1'b0;
      if (pend_q) begin
        irq_d  = 1'b1;
        pend_d = 1'b0;
        tc_d   = tmod_q;
        load_d = 1'b1;
      end
      if (inc_tick_i) begin
        if (tc_d == ALL1) pend_d = 1'b1;
        tc_d = tc_d + ONE;
      end
    end
    // write phase, after the tick
    if (inc_wr_i) begin
      if (tc_d == ALL1) pend_d = 1'b1;
      tc_d = tc_d + ONE;
    end
    if (wr_cnt_i && !load_d) begin
      tc_d   = wr_data_i;
      pend_d = 1'b0;
    end
    if (wr_mod_i) begin
      tmod_d = wr_data_i;
      if (load_d) tc_d = wr_data_i;
    end
    tc_en  = tick_i | inc_wr_i | wr_cnt_i | wr_mod_i;
    mod_en = wr_mod_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tc_q   <= '0;
      tmod_q <= '0;
      pend_q <= 1'b0;
      load_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (tc_en) begin
        tc_q   <= tc_d;
        pend_q <= pend_d;
        load_q <= load_d;
      end
      if (mod_en) begin
        tmod_q <= tmod_d;
      end
    end
  end

  assign tc_o   = tc_q;
  assign tmod_o = tmod_q;
  assign irq_o  = irq_q;

  // R7: wrap leaves zero and a pending reload
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_i && inc_tick_i && !pend_q && tc_q == ALL1 && !inc_wr_i && !wr_cnt_i && !wr_mod_i
    |=> tc_q == '0 && pend_q);
  // R7: reload tick loads modulo and raises the request
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_i && pend_q && !inc_tick_i && !inc_wr_i && !wr_mod_i
    |=> tc_q == $past(tmod_q) && irq_q);
  // R8: counter write in the delay cancels
  p_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pend_q && !tick_i && wr_cnt_i |=> !pend_q && tc_q == $past(wr_data_i));
  // R9: counter write in the reload window is dropped
  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    load_q && !tick_i && wr_cnt_i |=> $stable(tc_q));
  // R5/R6: a write-side falling edge adds exactly one
  p_wr_bump_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    inc_wr_i && !tick_i && tc_q != ALL1 |=> tc_q == $past(tc_q) + ONE);
endmodule

// File: rtl/divtimer_top.sv
`timescale 1ns/1ps
module divtimer_top #(
  parameter int CNT_W = 16,
  parameter int STEP  = 4,
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [TMR_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [TMR_W-1:0] rd_data_o,
  output logic             irq_o
);
  import divtimer_pkg::*;
  localparam int NLVL = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic wr_div, wr_cnt, wr_mod, wr_ctl;
  always_comb begin
    wr_div = wr_en_i && (wr_sel_i == SEL_DIV);
    wr_cnt = wr_en_i && (wr_sel_i == SEL_CNT);
    wr_mod = wr_en_i && (wr_sel_i == SEL_MOD);
    wr_ctl = wr_en_i && (wr_sel_i == SEL_CTL);
  end

  // control register
  logic [CTL_W-1:0] ctl_q, ctl_d;
  always_comb ctl_d = wr_ctl ? wr_data_i[CTL_W-1:0] : ctl_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_d;
  end

  logic [CNT_W-1:0] cnt_q, cnt_tick, cnt_next;
  divtimer_counter #(.CNT_W(CNT_W), .STEP(STEP)) u_cnt (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .tick_i     (tick_i),
    .clr_i      (wr_div),
    .cnt_o      (cnt_q),
    .cnt_tick_o (cnt_tick),
    .cnt_next_o (cnt_next)
  );

  // edge levels: before tick, after tick, after write
  logic [CTL_W-1:0] lv_ctl [NLVL];
  logic [CNT_W-1:0] lv_cnt [NLVL];
  logic [NLVL-1:0]  lvl;
  always_comb begin
    lv_ctl[0] = ctl_q; lv_cnt[0] = cnt_q;
    lv_ctl[1] = ctl_q; lv_cnt[1] = cnt_tick;
    lv_ctl[2] = ctl_d; lv_cnt[2] = cnt_next;
  end
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    divtimer_bitsel #(.CNT_W(CNT_W)) u_sel (
      .ctl_i (lv_ctl[g]),
      .cnt_i (lv_cnt[g]),
      .lvl_o (lvl[g])
    );
  end

  logic inc_tick, inc_wr;
  always_comb begin
    inc_tick = tick_i & lvl[0] & ~lvl[1];
    inc_wr   = lvl[1] & ~lvl[2];
  end

  logic [TMR_W-1:0] tc, tmod;
  divtimer_core #(.TMR_W(TMR_W)) u_core (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .tick_i     (tick_i),
    .inc_tick_i (inc_tick),
    .inc_wr_i   (inc_wr),
    .wr_cnt_i   (wr_cnt),
    .wr_mod_i   (wr_mod),
    .wr_data_i  (wr_data_i),
    .tc_o       (tc),
    .tmod_o     (tmod),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_DIV: rd_data_o = cnt_q[CNT_W-1 -: TMR_W];
      SEL_CNT: rd_data_o = tc;
      SEL_MOD: rd_data_o = tmod;
      default: rd_data_o = {{(TMR_W-CTL_W){1'b0}}, ctl_q};
    endcase
  end

  // R6: a control write to the same value never bumps the timer
  p_ctl_same_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_ctl && !tick_i && wr_data_i[CTL_W-1:0] == ctl_q |=> $stable(tc));
endmodule

// File: tb/tb_divtimer_top.sv
`timescale 1ns/1ps
module tb_divtimer_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, wen;
  logic [1:0] wsel, rsel;
  logic [7:0] wdata, rdata;
  logic       irq;

  always #2 clk = ~clk;

  divtimer_top dut (
    .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick), .wr_en_i(wen),
    .wr_sel_i(wsel), .wr_data_i(wdata), .rd_sel_i(rsel),
    .rd_data_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;

  // reference state
  int m_cnt, m_tc, m_mod, m_ctl, m_irq;
  bit m_pend, m_load;

  function automatic bit lvl(int ctl, int cnt);
    int pos[4] = '{9, 3, 5, 7};
    if ((ctl & 4) == 0) return 0;
    return bit'((cnt >> pos[ctl & 3]) & 1);
  endfunction

  function automatic void bump();
    if (m_tc == 255) m_pend = 1;
    m_tc = (m_tc + 1) & 255;
  endfunction

  function automatic void model(bit t, bit w, int s, int d);
    int nc;
    m_irq = 0;
    if (t) begin
      m_load = 0;
      if (m_pend) begin m_irq = 1; m_pend = 0; m_tc = m_mod; m_load = 1; end
      nc = (m_cnt + 4) & 16'hFFFF;
      if (lvl(m_ctl, m_cnt) && !lvl(m_ctl, nc)) bump();
      m_cnt = nc;
    end
    if (w) begin
      case (s)
        0: begin if (lvl(m_ctl, m_cnt)) bump(); m_cnt = 0; end
        1: if (!m_load) begin m_tc = d; m_pend = 0; end
        2: begin m_mod = d; if (m_load) m_tc = d; end
        default: begin
          if (lvl(m_ctl, m_cnt) && !lvl(d & 7, m_cnt)) bump();
          m_ctl = d & 7;
        end
      endcase
    end
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek(int s, output int v);
    rsel = 2'(s);
    #0.1;
    v = int'(rdata);
  endtask

  // full comparison against the model, once per clock
  task automatic compare_all();
    int v;
    bit ok = 1;
    peek(0, v); if (v != (m_cnt >> 8)) begin ok = 0; $display("FAIL R2 div actual=%0h expected=%0h", v, m_cnt >> 8); end
    peek(1, v); if (v != m_tc)  begin ok = 0; $display("FAIL R4 count actual=%0h expected=%0h", v, m_tc); end
    peek(2, v); if (v != m_mod) begin ok = 0; $display("FAIL R9 modulo actual=%0h expected=%0h", v, m_mod); end
    peek(3, v); if (v != m_ctl) begin ok = 0; $display("FAIL R6 control actual=%0h expected=%0h", v, m_ctl); end
    if (int'(irq) != m_irq) begin ok = 0; $display("FAIL R7 irq actual=%0h expected=%0h", irq, m_irq); end
    n_chk++;
    if (!ok) n_bad++;
  endtask

  task automatic cyc(bit t, bit w, int s, int d);
    tick = t; wen = w; wsel = 2'(s); wdata = 8'(d);
    model(t, w, s, d);
    @(posedge clk);
    #1;
    tick = 0; wen = 0;
    compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic expect_reg(int s, int exp, string tag);
    int v;
    peek(s, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", n_cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    int v;
    rst_n = 0; tick = 0; wen = 0; wsel = 0; wdata = 0; rsel = 0;
    m_cnt = 0; m_tc = 0; m_mod = 0; m_ctl = 0; m_irq = 0; m_pend = 0; m_load = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

    // R1 reset values
    expect_reg(0, 0, "R1 div");
    expect_reg(1, 0, "R1 count");
    expect_reg(2, 0, "R1 modulo");
    expect_reg(3, 0, "R1 control");
    check(irq == 0, "R1 irq", irq, 0);

    // R2 step and divider view; timer disabled so count stays
    ticks(64);
    expect_reg(0, 1, "R2 div after 64 ticks");
    expect_reg(1, 0, "R4 disabled timer");
    // R3 clear
    cyc(0, 1, 0, 8'h5A);
    expect_reg(0, 0, "R3 div cleared");
    // R4 rate 1 (bit 3), enabled
    cyc(0, 1, 3, 5);
    ticks(8);
    expect_reg(1, 2, "R4 two falling edges");
    // R5 clear with picked bit high
    ticks(2);
    cyc(0, 1, 0, 0);
    expect_reg(1, 3, "R5 clear edge");
    // R6 disable with level high, then re-enable
    ticks(2);
    cyc(0, 1, 3, 1);
    expect_reg(1, 4, "R6 disable edge");
    cyc(0, 1, 3, 5);
    expect_reg(1, 4, "R6 rising no bump");
    // R7 wrap, delay, reload
    cyc(0, 1, 1, 8'hFF);
    cyc(0, 1, 2, 8'h40);
    ticks(2);
    expect_reg(1, 0, "R7 zero after wrap");
    check(irq == 0, "R7 no irq at wrap", irq, 0);
    cyc(0, 0, 0, 0);
    expect_reg(1, 0, "R7 zero held until tick");
    ticks(1);
    check(irq == 1, "R7 irq on reload", irq, 1);
    expect_reg(1, 8'h40, "R7 modulo loaded");
    // R9 reload window
    cyc(0, 1, 1, 8'h11);
    check(irq == 0, "R7 single pulse", irq, 0);
    expect_reg(1, 8'h40, "R9 count write ignored");
    cyc(0, 1, 2, 8'h22);
    expect_reg(1, 8'h22, "R9 modulo write-through");
    ticks(1);
    cyc(0, 1, 1, 8'h11);
    expect_reg(1, 8'h11, "R9 window closed");
    // R8 cancel
    cyc(0, 1, 1, 8'hFF);
    ticks(2);
    cyc(0, 1, 1, 8'h33);
    ticks(1);
    check(irq == 0, "R8 irq cancelled", irq, 0);
    expect_reg(1, 8'h33, "R8 reload cancelled");
    // R10 tick and divider clear together
    cyc(1, 1, 0, 0);
    expect_reg(1, 8'h34, "R10 tick then clear edge");
    expect_reg(0, 0, "R10 clear wins");
    ticks(2);
    expect_reg(1, 8'h34, "R10 counter restarted at zero");

    // mixed stimulus, compared every clock against the model
    for (int i = 0; i < 6000; i++) begin
      int r, s, d;
      r = int'($urandom_range(0, 99));
      s = int'($urandom_range(0, 3));
      d = int'($urandom_range(0, 255));
      if (s == 1 && r < 8) d = 255;
      if (s == 0 && r > 3) s = 1;
      cyc(r < 70, r < 12 || r > 94, s, d);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule